// File: doc/BRIEF.md
# Channel-Level Hamming Corrector for Four Parallel Linear Transforms

This block guards four parallel data channels that each pass through an identical linear transform core, such as an FFT engine. It adds three spare channels. On the way in, it builds each spare channel's input as the sum of three of the four original inputs. On the way out, it compares each spare channel's result against the same sum of original results. Both comparisons are done per sample and separately for the real and imaginary parts. The transform is linear, so a healthy system keeps every comparison within a small tolerance. A fault in one core upsets a pattern of comparisons that is unique to that core.

The three comparison outcomes form a 3-bit syndrome, read as a single-error-correcting Hamming code across whole channels. When the syndrome points at an original channel, that channel's sample is rebuilt from a spare output minus the other members of its group. A multiplexer then puts the rebuilt sample in place of the raw one. When the syndrome points only at a spare channel, the data passes unchanged. Every output sample carries an error flag that is raised whenever any comparison failed. The transform cores sit outside the block. The integrator wires the spare inputs to three extra cores and feeds their outputs back.

Top module: `chan_hamming_guard`

## Requirements
- R1: Spare input k is the sign-extended sum of three original inputs, taken separately for the real and imaginary parts, with width DATA_W+2. Original channel n (1..4) occupies bits [(n-1)*DATA_W +: DATA_W]. The groups are: spare 1 = {1,2,3}, spare 2 = {1,2,4}, spare 3 = {1,3,4}. Spare k occupies bits [(k-1)*(DATA_W+2) +: DATA_W+2].
- R2: Check k passes when the real parts and the imaginary parts each differ from the matching group sum of original outputs by at most TOL (default 1). A difference of TOL passes. A difference of TOL+1 fails.
- R3: When all three checks pass, every output sample equals its raw input sample and the error flag is 0.
- R4: The syndrome is {c1,c2,c3}, with c1 as the MSB. The value 111 marks channel 1, 110 marks channel 2, 101 marks channel 3 and 011 marks channel 4. The marked channel is rebuilt as follows: ch1 = spare1 − y2 − y3; ch2 = spare1 − y1 − y3; ch3 = spare1 − y1 − y2; ch4 = spare2 − y1 − y2. The other three channels pass unchanged.
- R5: A syndrome with exactly one bit set (100, 010 or 001) marks a fault in a spare channel. All four outputs then equal the raw inputs.
- R6: The error flag of an output sample is 1 exactly when its syndrome is non-zero.
- R7: An output sample appears one clock after its input sample, with z_vld following y_vld. While y_vld is low, z_vld drops and the data outputs hold their last values.
- R8: A rebuilt value outside the signed DATA_W range saturates to the nearest limit (+32767 or −32768 at the default width).
- R9: During reset, z_vld, z_err, z_re and z_im are all 0.
- R10: A fault present only in the imaginary part is detected and corrected the same way as one in the real part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_re | input | 4*DATA_W | Real parts of the four original transform inputs |
| x_im | input | 4*DATA_W | Imaginary parts of the four original transform inputs |
| xr_re | output | 3*(DATA_W+2) | Real parts of the three spare transform inputs |
| xr_im | output | 3*(DATA_W+2) | Imaginary parts of the three spare transform inputs |
| y_vld | input | 1 | Output samples of all seven cores are valid |
| y_re | input | 4*DATA_W | Real parts of the four original transform outputs |
| y_im | input | 4*DATA_W | Imaginary parts of the four original transform outputs |
| yr_re | input | 3*(DATA_W+2) | Real parts of the three spare transform outputs |
| yr_im | input | 3*(DATA_W+2) | Imaginary parts of the three spare transform outputs |
| z_vld | output | 1 | Corrected sample valid |
| z_re | output | 4*DATA_W | Real parts of the corrected outputs |
| z_im | output | 4*DATA_W | Imaginary parts of the corrected outputs |
| z_err | output | 1 | At least one check failed for this sample |

## Verification
The hardest case to reach is a rebuilt value that goes out of range. Saturation needs a spare output that disagrees with the originals at the same time as an original channel is faulty. A single consistent fault can never produce it. The bench therefore drives the transform-output ports directly. It forms exact group sums and then corrupts one original channel, a spare channel, or both together with large magnitudes. It also places differences exactly at TOL and at TOL+1 to probe the edge of the tolerance.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

  localparam int NCH   = 4;  // original channels
  localparam int NCHK  = 3;  // spare channels / checks
  localparam int NHOME = 2;  // checks used as rebuild sources

  typedef enum logic [1:0] {
    SYN_CLEAN,
    SYN_SPARE,
    SYN_DATA
  } syn_class_e;

  // Group membership of check k, bit n = original channel n+1
  function automatic logic [NCH-1:0] grp_mask(input int k);
    case (k)
      0:       return 4'b0111;
      1:       return 4'b1011;
      default: return 4'b1101;
    endcase
  endfunction

  // Syndrome {c1,c2,c3} to one-hot faulty original channel
  function automatic logic [NCH-1:0] fault_onehot(input logic [NCHK-1:0] syn);
    case (syn)
      3'b111:  return 4'b0001;
      3'b110:  return 4'b0010;
      3'b101:  return 4'b0100;
      3'b011:  return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic syn_class_e classify(input logic [NCHK-1:0] syn);
    case ($countones(syn))
      0:       return SYN_CLEAN;
      1:       return SYN_SPARE;
      default: return SYN_DATA;
    endcase
  endfunction

  // Check whose spare output rebuilds a given channel
  function automatic int home_chk(input int ch);
    return (ch == NCH - 1) ? 1 : 0;
  endfunction

endpackage

// File: rtl/hcg_enc.sv
module hcg_enc #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 2
) (
  input  logic [hcg_pkg::NCH*DATA_W-1:0]             v_re,
  input  logic [hcg_pkg::NCH*DATA_W-1:0]             v_im,
  output logic [hcg_pkg::NCHK*(DATA_W+GUARD_W)-1:0]  s_re,
  output logic [hcg_pkg::NCHK*(DATA_W+GUARD_W)-1:0]  s_im
);
  import hcg_pkg::*;

  localparam int SW = DATA_W + GUARD_W;

  function automatic logic signed [SW-1:0] grp_sum(input logic [NCH*DATA_W-1:0] v,
                                                   input logic [NCH-1:0] m);
    logic signed [SW-1:0] acc;
    acc = '0;
    for (int j = 0; j < NCH; j++)
      if (m[j]) acc = acc + SW'(signed'(v[j*DATA_W +: DATA_W]));
    return acc;
  endfunction

  for (genvar k = 0; k < NCHK; k++) begin : g_grp
    assign s_re[k*SW +: SW] = grp_sum(v_re, grp_mask(k));
    assign s_im[k*SW +: SW] = grp_sum(v_im, grp_mask(k));
  end

endmodule

// File: rtl/hcg_check.sv
module hcg_check #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 2,
  parameter int TOL     = 1
) (
  input  logic [DATA_W+GUARD_W-1:0] r_re,
  input  logic [DATA_W+GUARD_W-1:0] r_im,
  input  logic [DATA_W+GUARD_W-1:0] s_re,
  input  logic [DATA_W+GUARD_W-1:0] s_im,
  output logic                      fail
);
  localparam int SW = DATA_W + GUARD_W;
  localparam int EW = SW + 1;

  function automatic logic off_tol(input logic [SW-1:0] r, input logic [SW-1:0] s);
    logic signed [EW-1:0] d;
    logic signed [EW-1:0] mag;
    d   = EW'(signed'(r)) - EW'(signed'(s));
    mag = (d < 0) ? -d : d;
    return mag > EW'(TOL);
  endfunction

  logic miss_re, miss_im;
  assign miss_re = off_tol(r_re, s_re);
  assign miss_im = off_tol(r_im, s_im);
  assign fail    = miss_re | miss_im;

endmodule

// File: rtl/hcg_fix.sv
module hcg_fix #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 2
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         v_in,
  input  logic [hcg_pkg::NCH*DATA_W-1:0]               y_re,
  input  logic [hcg_pkg::NCH*DATA_W-1:0]               y_im,
  input  logic [hcg_pkg::NHOME*(DATA_W+GUARD_W)-1:0]   r_re,
  input  logic [hcg_pkg::NHOME*(DATA_W+GUARD_W)-1:0]   r_im,
  input  logic [hcg_pkg::NCHK-1:0]                     syn,
  output logic                                         z_vld,
  output logic [hcg_pkg::NCH*DATA_W-1:0]               z_re,
  output logic [hcg_pkg::NCH*DATA_W-1:0]               z_im,
  output logic                                         z_err
);
  import hcg_pkg::*;

  localparam int SW = DATA_W + GUARD_W;
  localparam int RW = SW + 1;
  localparam logic signed [RW-1:0] SAT_HI = {{(RW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [RW-1:0] SAT_LO = {{(RW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  function automatic logic signed [RW-1:0] rebuild(input logic [NHOME*SW-1:0] r,
                                                   input logic [NCH*DATA_W-1:0] y,
                                                   input int ch);
    logic [NCH-1:0]       m;
    int                   k;
    logic signed [RW-1:0] acc;
    k   = home_chk(ch);
    m   = grp_mask(k);
    acc = RW'(signed'(r[k*SW +: SW]));
    for (int i = 0; i < NCH; i++)
      if (m[i] && i != ch) acc = acc - RW'(signed'(y[i*DATA_W +: DATA_W]));
    return acc;
  endfunction

  function automatic logic [DATA_W-1:0] sat(input logic signed [RW-1:0] v);
    if (v > SAT_HI)      return SAT_HI[DATA_W-1:0];
    else if (v < SAT_LO) return SAT_LO[DATA_W-1:0];
    else                 return v[DATA_W-1:0];
  endfunction

  // Named internal events for the assertions
  logic [NCH-1:0]        fault_oh;
  syn_class_e            syn_cls;
  logic                  any_fail;
  logic [NCH*DATA_W-1:0] sel_re, sel_im;

  assign fault_oh = fault_onehot(syn);
  assign syn_cls  = classify(syn);
  assign any_fail = |syn;

  for (genvar j = 0; j < NCH; j++) begin : g_ch
    logic [DATA_W-1:0] fix_re, fix_im;
    assign fix_re = sat(rebuild(r_re, y_re, j));
    assign fix_im = sat(rebuild(r_im, y_im, j));
    assign sel_re[j*DATA_W +: DATA_W] = fault_oh[j] ? fix_re : y_re[j*DATA_W +: DATA_W];
    assign sel_im[j*DATA_W +: DATA_W] = fault_oh[j] ? fix_im : y_im[j*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_vld <= 1'b0;
      z_err <= 1'b0;
      z_re  <= '0;
      z_im  <= '0;
    end else begin
      z_vld <= v_in;
      if (v_in) begin
        z_re  <= sel_re;
        z_im  <= sel_im;
        z_err <= any_fail;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> z_vld); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !v_in |=> (!z_vld && $stable(z_re) && $stable(z_im))); // R7
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    v_in |=> (z_err == ($past(syn) != '0))); // R6
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && syn_cls == SYN_CLEAN) |=> (z_re == $past(y_re) && z_im == $past(y_im))); // R3
  AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && syn_cls == SYN_SPARE) |=> (z_re == $past(y_re) && z_im == $past(y_im))); // R5
  AST_ONE_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_cls == SYN_DATA) |-> ($countones(fault_oh) == 1)); // R4

endmodule

// File: rtl/chan_hamming_guard.sv
module chan_hamming_guard #(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 2,
  parameter int TOL     = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [4*DATA_W-1:0]              x_re,
  input  logic [4*DATA_W-1:0]              x_im,
  output logic [3*(DATA_W+GUARD_W)-1:0]    xr_re,
  output logic [3*(DATA_W+GUARD_W)-1:0]    xr_im,
  input  logic                             y_vld,
  input  logic [4*DATA_W-1:0]              y_re,
  input  logic [4*DATA_W-1:0]              y_im,
  input  logic [3*(DATA_W+GUARD_W)-1:0]    yr_re,
  input  logic [3*(DATA_W+GUARD_W)-1:0]    yr_im,
  output logic                             z_vld,
  output logic [4*DATA_W-1:0]              z_re,
  output logic [4*DATA_W-1:0]              z_im,
  output logic                             z_err
);
  import hcg_pkg::*;

  localparam int SW = DATA_W + GUARD_W;

  logic [NCHK*SW-1:0] ys_re, ys_im;   // group sums of original outputs
  logic [NCHK-1:0]    chk_fail;       // chk_fail[k] = check k+1 failed
  logic [NCHK-1:0]    syn;            // {c1,c2,c3}

  hcg_enc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_enc_in (
    .v_re(x_re), .v_im(x_im), .s_re(xr_re), .s_im(xr_im)
  );

  hcg_enc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_enc_out (
    .v_re(y_re), .v_im(y_im), .s_re(ys_re), .s_im(ys_im)
  );

  for (genvar k = 0; k < NCHK; k++) begin : g_chk
    hcg_check #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .TOL(TOL)) u_chk (
      .r_re(yr_re[k*SW +: SW]), .r_im(yr_im[k*SW +: SW]),
      .s_re(ys_re[k*SW +: SW]), .s_im(ys_im[k*SW +: SW]),
      .fail(chk_fail[k])
    );
    assign syn[NCHK-1-k] = chk_fail[k];
  end

  hcg_fix #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_fix (
    .clk(clk), .rst_n(rst_n), .v_in(y_vld),
    .y_re(y_re), .y_im(y_im),
    .r_re(yr_re[NHOME*SW-1:0]), .r_im(yr_im[NHOME*SW-1:0]),
    .syn(syn),
    .z_vld(z_vld), .z_re(z_re), .z_im(z_im), .z_err(z_err)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!z_vld && !z_err && z_re == '0 && z_im == '0)); // R9

endmodule

// File: tb/sim_chan_hamming_guard.sv
module sim_chan_hamming_guard;
  localparam int CLK_NS = 10;
  localparam int DW     = 16;
  localparam int SW     = 18;
  localparam int TOL    = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [4*DW-1:0] x_re, x_im, y_re, y_im, z_re, z_im;
  logic [3*SW-1:0] xr_re, xr_im, yr_re, yr_im;
  logic            y_vld, z_vld, z_err;

  chan_hamming_guard u0 (
    .clk(clk), .rst_n(rst_n), .x_re(x_re), .x_im(x_im), .xr_re(xr_re), .xr_im(xr_im),
    .y_vld(y_vld), .y_re(y_re), .y_im(y_im), .yr_re(yr_re), .yr_im(yr_im),
    .z_vld(z_vld), .z_re(z_re), .z_im(z_im), .z_err(z_err)
  );

  int checks = 0;
  int failures = 0;

  // membership: member[k][n] = 1 when channel n+1 belongs to check k+1
  int member [3][4] = '{'{1,1,1,0}, '{1,1,0,1}, '{1,0,1,1}};
  int yre[4], yim[4], rre[3], rim[3];

  typedef struct {
    logic [4*DW-1:0] re;
    logic [4*DW-1:0] im;
    logic            err;
    string           tag;
  } exp_t;
  exp_t sbq[$];
  exp_t last_exp;

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int rnd(input int lim);
    return int'($urandom_range(2*lim)) - lim;
  endfunction

  task automatic make_clean();
    for (int k = 0; k < 3; k++) begin
      rre[k] = 0; rim[k] = 0;
      for (int n = 0; n < 4; n++)
        if (member[k][n] != 0) begin rre[k] += yre[n]; rim[k] += yim[n]; end
    end
  endtask

  task automatic random_base();
    for (int n = 0; n < 4; n++) begin yre[n] = rnd(15000); yim[n] = rnd(15000); end
    make_clean();
  endtask

  // Driver: model the expected result, then drive and push it
  task automatic send(input string tag);
    bit   bad_chk[3];
    int   bad, kk, vr, vi, sr, si;
    bit   match;
    exp_t e;
    for (int k = 0; k < 3; k++) begin
      sr = 0; si = 0;
      for (int n = 0; n < 4; n++)
        if (member[k][n] != 0) begin sr += yre[n]; si += yim[n]; end
      bad_chk[k] = (iabs(rre[k] - sr) > TOL) || (iabs(rim[k] - si) > TOL);
    end
    bad = -1;
    for (int n = 0; n < 4; n++) begin
      match = 1'b1;
      for (int k = 0; k < 3; k++)
        if ((member[k][n] != 0) != bad_chk[k]) match = 1'b0;
      if (match) bad = n;
    end
    e.err = bad_chk[0] | bad_chk[1] | bad_chk[2];
    for (int n = 0; n < 4; n++) begin
      vr = yre[n]; vi = yim[n];
      if (n == bad) begin
        kk = -1;
        for (int k = 0; k < 3; k++) if (kk < 0 && member[k][n] != 0) kk = k;
        vr = rre[kk]; vi = rim[kk];
        for (int i = 0; i < 4; i++)
          if (i != n && member[kk][i] != 0) begin vr -= yre[i]; vi -= yim[i]; end
        vr = clamp16(vr); vi = clamp16(vi);
      end
      e.re[n*DW +: DW] = 16'(vr);
      e.im[n*DW +: DW] = 16'(vi);
    end
    e.tag = tag;
    @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      y_re[n*DW +: DW] = 16'(yre[n]);
      y_im[n*DW +: DW] = 16'(yim[n]);
    end
    for (int k = 0; k < 3; k++) begin
      yr_re[k*SW +: SW] = 18'(rre[k]);
      yr_im[k*SW +: SW] = 18'(rim[k]);
    end
    y_vld = 1'b1;
    sbq.push_back(e);
    last_exp = e;
  endtask

  // Monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && z_vld) begin
      if (sbq.size() == 0) begin
        note(1'b0, "R7", "unexpected z_vld", 64'(z_vld), 64'd0);
      end else begin
        e = sbq.pop_front();
        note(z_re == e.re, e.tag, "z_re", z_re, e.re);
        note(z_im == e.im, e.tag, "z_im", z_im, e.im);
        note(z_err == e.err, e.tag, "z_err", 64'(z_err), 64'(e.err));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    note(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int xa[4], xb[4], sa, sb, d;
    x_re = '0; x_im = '0; y_re = '0; y_im = '0; yr_re = '0; yr_im = '0; y_vld = 1'b0;
    repeat (3) @(negedge clk);
    note(z_vld == 1'b0, "R9", "z_vld in reset", 64'(z_vld), 64'd0);
    note(z_err == 1'b0, "R9", "z_err in reset", 64'(z_err), 64'd0);
    note(z_re == '0, "R9", "z_re in reset", z_re, 64'd0);
    note(z_im == '0, "R9", "z_im in reset", z_im, 64'd0);
    rst_n = 1'b1;

    // R1: spare input sums, extremes and random
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 4; n++) begin
        case (p)
          0: begin xa[n] = 32767;  xb[n] = -32768; end
          1: begin xa[n] = -32768; xb[n] = 32767;  end
          2: begin xa[n] = (n % 2 == 0) ? 32767 : -32768; xb[n] = n - 2; end
          default: begin xa[n] = rnd(32767); xb[n] = rnd(32767); end
        endcase
        x_re[n*DW +: DW] = 16'(xa[n]);
        x_im[n*DW +: DW] = 16'(xb[n]);
      end
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        sa = 0; sb = 0;
        for (int n = 0; n < 4; n++)
          if (member[k][n] != 0) begin sa += xa[n]; sb += xb[n]; end
        note(int'($signed(xr_re[k*SW +: SW])) == sa, "R1", "spare input re",
             64'(xr_re[k*SW +: SW]), 64'(18'(sa)));
        note(int'($signed(xr_im[k*SW +: SW])) == sb, "R1", "spare input im",
             64'(xr_im[k*SW +: SW]), 64'(18'(sb)));
      end
    end

    // R3/R6: clean streams, back to back
    for (int i = 0; i < 20; i++) begin random_base(); send("R3/R6 clean"); end

    // R2: tolerance edges
    random_base(); rre[0] += 1;            send("R2 diff=+TOL passes");
    random_base(); rim[1] -= 1;            send("R2 diff=-TOL passes");
    random_base(); yre[3] += 1; yim[0] -= 1; send("R2 data off by TOL passes");
    random_base(); rre[0] += 2;            send("R2/R5 diff=TOL+1 fails");
    random_base(); yre[3] -= 2;            send("R2/R4 data off by TOL+1 fixed");

    // R4/R10: single data-channel faults, real and imaginary
    for (int n = 0; n < 4; n++)
      for (int r = 0; r < 3; r++) begin
        d = 2 + int'($urandom_range(3000));
        random_base(); yre[n] += (r == 1) ? -d : d; send("R4/R6 data fault re");
        random_base(); yim[n] -= d;                 send("R10 data fault im only");
      end

    // R5: spare faults
    for (int k = 0; k < 3; k++) begin
      d = 2 + int'($urandom_range(3000));
      random_base(); rre[k] += d; send("R5/R6 spare fault re");
      random_base(); rim[k] -= d; send("R5/R6 spare fault im");
    end

    // R8: rebuilt value beyond range saturates
    yre = '{100, -20000, -20000, 0}; yim = '{0, 0, 0, 0}; make_clean();
    yre[0] = 5000; rre[0] = 30000;  send("R8 saturate high (+32767)");
    yre = '{100, 20000, 20000, 0}; yim = '{-5, 20000, 20000, 7}; make_clean();
    yre[0] = -5000; rre[0] = -30000; yim[0] = 9000; rim[0] = -30000;
    send("R8 saturate low (-32768)");

    // R7: idle cycle holds data and drops valid
    random_base(); send("R7 last before idle");
    @(negedge clk);
    y_vld = 1'b0; y_re = ~y_re; y_im = ~y_im;
    @(negedge clk);
    note(z_vld == 1'b0, "R7", "z_vld while idle", 64'(z_vld), 64'd0);
    note(z_re == last_exp.re, "R7", "z_re held", z_re, last_exp.re);
    note(z_im == last_exp.im, "R7", "z_im held", z_im, last_exp.im);
    random_base(); send("R7 resume after idle");
    @(negedge clk);
    y_vld = 1'b0;
    repeat (3) @(negedge clk);
    note(sbq.size() == 0, "R7", "scoreboard drained", 64'(sbq.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule